// File: doc/BRIEF.md
# External Interrupt Trigger Unit

This block turns up to six asynchronous interrupt pins into per-pin interrupt requests for a downstream interrupt controller. Each pin is brought into the clock domain through a two-stage synchroniser. A trigger detector then decides whether the pin's activity counts as an event: a rising edge, a falling edge, either edge, a high level or a low level, or nothing at all. Three registers on a 32-bit register bus control the unit. The mode register holds a 4-bit trigger code per pin. The pending register shows and clears captured events. The enable register gates each pending bit onto its request output.

Each pin owns a small state machine with three states. PS_QUIET means nothing is pending. PS_HELD means an edge was captured and is held. PS_LEVEL means a level trigger is active now. The transitions are:
- capture: PS_QUIET to PS_HELD on a qualifying edge.
- release: PS_HELD or PS_LEVEL to PS_QUIET on a clear write that has no edge in the same cycle.
- retain: PS_LEVEL to PS_HELD when the pin leaves a level mode.
- follow: any state to PS_LEVEL or PS_QUIET, as the active level dictates, while in a level mode.

Register reads are combinational from the address. Writes take effect at the clock edge.

Top module: `ext_irq_trigger`

## Requirements
- R1: After reset every pin's mode field holds code 6 (low level), the enable register is zero and all requests are low.
- R2: The mode register is at byte offset 0x0, with pin i in bits [4i+3:4i]. Pending is at 0x8 and enable at 0xC, each using bit i for pin i. Register bits above the implemented pins read 0. Offset 0x4 reads 0 and ignores writes.
- R3: Mode code 1 (rising) sets the pin's pending bit on a 0-to-1 transition of the pin.
- R4: Mode code 2 (falling) sets the pending bit on a 1-to-0 transition.
- R5: Mode code 3 (either edge) sets the pending bit on a transition in either direction.
- R6: In edge modes a pending bit stays set until a write to 0x8 with bit i equal to 0 clears it. Writing 1 has no effect. An edge in the same cycle as the clear wins and leaves the bit set.
- R7: In mode 5 the pending bit equals the synchronised pin level. In mode 6 it equals the inverted level. It follows the level every cycle, and clear writes have no lasting effect.
- R8: Codes 0, 4 and 7 to 15 never set a pending bit. A bit already set stays set until it is cleared.
- R9: Request i equals pending bit i ANDed with enable bit i. Pending bits are captured whatever the enable setting.
- R10: A change on a pin shows in its pending bit after the third rising clock edge following the change, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | NUM_PINS | Asynchronous interrupt pins |
| bus_addr | input | 4 | Register byte offset |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| irq_req | output | NUM_PINS | Per-pin request to the interrupt controller |

## Verification
The hardest case to reach is a clear write that lands in exactly the cycle in which a synchronised edge reaches the pin state machine. To hit it, the bench starts the write two falling edges after driving the pin. Another hard case is a pin leaving a level mode while its bit is set, which should move it from PS_LEVEL to PS_HELD rather than drop the bit. Random mode rewrites, which include the unused codes, reach this path along with random pin toggles and random clear patterns. All of these are compared each cycle against a bench model of the trigger rules.

// File: rtl/eit_pkg.sv
package eit_pkg;

    localparam int MODE_BITS = 4;
    localparam int BUS_W     = 32;
    localparam int ADDR_W    = 4;

    localparam logic [ADDR_W-1:0] OFF_MODE = 4'h0;
    localparam logic [ADDR_W-1:0] OFF_AUX  = 4'h4;
    localparam logic [ADDR_W-1:0] OFF_PEND = 4'h8;
    localparam logic [ADDR_W-1:0] OFF_EN   = 4'hC;

    localparam logic [MODE_BITS-1:0] CODE_RISE = 4'd1;
    localparam logic [MODE_BITS-1:0] CODE_FALL = 4'd2;
    localparam logic [MODE_BITS-1:0] CODE_ANY  = 4'd3;
    localparam logic [MODE_BITS-1:0] CODE_HIGH = 4'd5;
    localparam logic [MODE_BITS-1:0] CODE_LOW  = 4'd6;

    typedef enum logic [2:0] {
        TRIG_OFF, TRIG_RISE, TRIG_FALL, TRIG_ANY, TRIG_HIGH, TRIG_LOW
    } trig_kind_e;

    typedef enum logic [1:0] {
        PS_QUIET, PS_HELD, PS_LEVEL
    } pin_state_e;

    function automatic trig_kind_e decode_trig(input logic [MODE_BITS-1:0] code);
        trig_kind_e k;
        case (code)
            CODE_RISE: k = TRIG_RISE;
            CODE_FALL: k = TRIG_FALL;
            CODE_ANY:  k = TRIG_ANY;
            CODE_HIGH: k = TRIG_HIGH;
            CODE_LOW:  k = TRIG_LOW;
            default:   k = TRIG_OFF;
        endcase
        return k;
    endfunction

endpackage

// File: rtl/eit_sync.sv
module eit_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '0;
                else        chain <= d;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '0;
                else        chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/eit_pin_cell.sv
module eit_pin_cell
    import eit_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 pin_async,
    input  logic [MODE_BITS-1:0] mode,
    input  logic                 clr,
    output logic                 pending
);
    logic       lvl;
    logic       prev_q;
    logic       rise, fall, hit_edge, level_mode, level_on;
    trig_kind_e kind;
    pin_state_e state_q, state_d;

    eit_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(pin_async), .q(lvl)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= lvl;
    end

    always_comb begin
        kind       = decode_trig(mode);
        rise       = lvl & ~prev_q;
        fall       = ~lvl & prev_q;
        hit_edge   = 1'b0;
        level_mode = 1'b0;
        level_on   = 1'b0;
        unique case (kind)
            TRIG_RISE: hit_edge = rise;
            TRIG_FALL: hit_edge = fall;
            TRIG_ANY:  hit_edge = rise | fall;
            TRIG_HIGH: begin level_mode = 1'b1; level_on = lvl;  end
            TRIG_LOW:  begin level_mode = 1'b1; level_on = ~lvl; end
            default:   hit_edge = 1'b0;
        endcase
    end

    // next-state selection: follow / capture / release / retain
    always_comb begin
        state_d = state_q;
        if (level_mode) begin
            state_d = level_on ? PS_LEVEL : PS_QUIET;
        end else begin
            unique case (state_q)
                PS_QUIET: state_d = hit_edge ? PS_HELD : PS_QUIET;
                PS_HELD,
                PS_LEVEL: state_d = (clr && !hit_edge) ? PS_QUIET : PS_HELD;
                default:  state_d = PS_QUIET;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PS_QUIET;
        else        state_q <= state_d;
    end

    always_comb begin
        pending = (state_q != PS_QUIET);
    end
endmodule

// File: rtl/eit_regs.sv
module eit_regs
    import eit_pkg::*;
#(
    parameter int NUM_PINS = 6,
    localparam int MODE_W  = NUM_PINS * MODE_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [BUS_W-1:0]  bus_wdata,
    input  logic [NUM_PINS-1:0] pend_in,
    output logic [MODE_W-1:0] mode_q,
    output logic [NUM_PINS-1:0] en_q,
    output logic [NUM_PINS-1:0] clr,
    output logic [BUS_W-1:0]  bus_rdata
);
    logic unused_hi;
    assign unused_hi = ^bus_wdata[BUS_W-1:MODE_W];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_PINS; i++) mode_q[i*MODE_BITS +: MODE_BITS] <= CODE_LOW;
            en_q <= '0;
        end else if (bus_wr) begin
            if (bus_addr == OFF_MODE) mode_q <= bus_wdata[MODE_W-1:0];
            if (bus_addr == OFF_EN)   en_q   <= bus_wdata[NUM_PINS-1:0];
        end
    end

    always_comb begin
        clr = (bus_wr && bus_addr == OFF_PEND) ? ~bus_wdata[NUM_PINS-1:0] : '0;
    end

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            OFF_MODE: bus_rdata[MODE_W-1:0]   = mode_q;
            OFF_PEND: bus_rdata[NUM_PINS-1:0] = pend_in;
            OFF_EN:   bus_rdata[NUM_PINS-1:0] = en_q;
            default:  bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/ext_irq_trigger.sv
module ext_irq_trigger
    import eit_pkg::*;
#(
    parameter int NUM_PINS    = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_in,
    input  logic [3:0]          bus_addr,
    input  logic                bus_wr,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    output logic [NUM_PINS-1:0] irq_req
);
    localparam int MODE_W = NUM_PINS * MODE_BITS;

    logic [MODE_W-1:0]   mode_q;
    logic [NUM_PINS-1:0] en_q;
    logic [NUM_PINS-1:0] clr;
    logic [NUM_PINS-1:0] pend_q;

    eit_regs #(.NUM_PINS(NUM_PINS)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .pend_in(pend_q), .mode_q(mode_q), .en_q(en_q), .clr(clr),
        .bus_rdata(bus_rdata)
    );

    generate
        for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
            eit_pin_cell #(.SYNC_STAGES(SYNC_STAGES)) u_cell (
                .clk(clk), .rst_n(rst_n),
                .pin_async(pin_in[i]),
                .mode(mode_q[i*MODE_BITS +: MODE_BITS]),
                .clr(clr[i]),
                .pending(pend_q[i])
            );
        end
    endgenerate

    assign irq_req = pend_q & en_q;
endmodule

// File: rtl/ext_irq_trigger_chk.sv
module ext_irq_trigger_chk
    import eit_pkg::*;
#(
    parameter int NUM_PINS = 6
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic [3:0]                    bus_addr,
    input logic                          bus_wr,
    input logic [31:0]                   bus_wdata,
    input logic [31:0]                   bus_rdata,
    input logic [NUM_PINS-1:0]           irq_req,
    input logic [NUM_PINS*MODE_BITS-1:0] mode_q,
    input logic [NUM_PINS-1:0]           en_q,
    input logic [NUM_PINS-1:0]           pend_q
);
    p_aux_reads_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == OFF_AUX) |-> (bus_rdata == 32'd0));

    generate
        for (genvar i = 0; i < NUM_PINS; i++) begin : g_chk
            logic [MODE_BITS-1:0] code;
            logic edge_code, off_code, clr_i;
            assign code      = mode_q[i*MODE_BITS +: MODE_BITS];
            assign edge_code = (code == CODE_RISE) || (code == CODE_FALL) || (code == CODE_ANY);
            assign off_code  = !edge_code && (code != CODE_HIGH) && (code != CODE_LOW);
            assign clr_i     = bus_wr && (bus_addr == OFF_PEND) && !bus_wdata[i];

            p_req_needs_enable_r9: assert property (@(posedge clk) disable iff (!rst_n)
                irq_req[i] |-> en_q[i]);

            p_edge_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
                (edge_code && pend_q[i] && !clr_i) |=> pend_q[i]);

            p_off_stays_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
                (off_code && !pend_q[i]) |=> !pend_q[i]);
        end
    endgenerate
endmodule

bind ext_irq_trigger ext_irq_trigger_chk #(.NUM_PINS(NUM_PINS)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_req(irq_req),
    .mode_q(mode_q), .en_q(en_q), .pend_q(pend_q)
);

// File: tb/ext_irq_trigger_bench.sv
module ext_irq_trigger_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [NP-1:0] pin_in = '0;
    logic [3:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [NP-1:0] irq_req;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    ext_irq_trigger u_ext_irq_trigger (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_req(irq_req)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // reference model of the trigger rules
    logic [NP-1:0] m_s1, m_s2, m_pv, m_en, m_pend;
    logic [4*NP-1:0] m_mode;

    function automatic logic [NP-1:0] next_pend(
        input logic [4*NP-1:0] modes, input logic [NP-1:0] lvl, input logic [NP-1:0] prv,
        input logic [NP-1:0] pend, input logic [NP-1:0] clrv);
        logic [NP-1:0] r;
        for (int i = 0; i < NP; i++) begin
            logic [3:0] c;
            logic up, dn;
            c  = modes[4*i +: 4];
            up = lvl[i] & ~prv[i];
            dn = ~lvl[i] & prv[i];
            case (c)
                4'd5:    r[i] = lvl[i];
                4'd6:    r[i] = ~lvl[i];
                4'd1:    r[i] = (pend[i] & ~clrv[i]) | up;
                4'd2:    r[i] = (pend[i] & ~clrv[i]) | dn;
                4'd3:    r[i] = (pend[i] & ~clrv[i]) | up | dn;
                default: r[i] = pend[i] & ~clrv[i];
            endcase
        end
        return r;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_s1 <= '0; m_s2 <= '0; m_pv <= '0; m_en <= '0; m_pend <= '0;
            m_mode <= 24'h666666;
        end else begin
            m_s1 <= pin_in; m_s2 <= m_s1; m_pv <= m_s2;
            m_pend <= next_pend(m_mode, m_s2, m_pv, m_pend,
                (bus_wr && bus_addr == 4'h8) ? ~bus_wdata[NP-1:0] : '0);
            if (bus_wr && bus_addr == 4'h0) m_mode <= bus_wdata[4*NP-1:0];
            if (bus_wr && bus_addr == 4'hC) m_en <= bus_wdata[NP-1:0];
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic read_reg(input logic [3:0] a, output logic [31:0] v);
        bus_wr = 1'b0;
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        read_reg(4'h0, v); check("R1 mode reset", v, 32'h0066_6666);
        read_reg(4'hC, v); check("R1 enable reset", v, 32'h0);
        check("R1 requests reset", {26'd0, irq_req}, 32'h0);

        // R7 low level with pins low, clear has no lasting effect
        repeat (3) @(negedge clk);
        read_reg(4'h8, v); check("R7 low level pending", v, 32'h3F);
        bus_write(4'h8, 32'h0);
        read_reg(4'h8, v); check("R7 clear ignored in level mode", v, 32'h3F);

        // R2 register map
        bus_write(4'h4, 32'hFFFF_FFFF);
        read_reg(4'h4, v); check("R2 aux offset reads zero", v, 32'h0);
        bus_write(4'h0, 32'hFFFF_FFFF);
        read_reg(4'h0, v); check("R2 mode upper bits zero", v, 32'h00FF_FFFF);
        bus_write(4'hC, 32'hFFFF_FFFF);
        read_reg(4'hC, v); check("R2 enable width", v, 32'h3F);

        // R8 unused code holds then never sets
        read_reg(4'h8, v); check("R8 held after leaving level", v, 32'h3F);
        bus_write(4'h8, 32'h0);
        read_reg(4'h8, v); check("R8 cleared", v, 32'h0);
        pin_in = 6'h3F; repeat (4) @(negedge clk);
        read_reg(4'h8, v); check("R8 no set on rise", v, 32'h0);
        pin_in = 6'h00; repeat (4) @(negedge clk);
        read_reg(4'h8, v); check("R8 no set on fall", v, 32'h0);

        // pin0 rise, pin1 fall, pin2 any, pin3 high, pin4 low, pin5 off
        bus_write(4'h0, 32'h0006_5321);
        @(negedge clk);
        read_reg(4'h8, v); check("R7 low level after mode write", v, 32'h10);
        pin_in = 6'h3F;
        repeat (2) @(negedge clk);
        read_reg(4'h8, v); check("R10 not before third edge", v, 32'h10);
        @(negedge clk);
        read_reg(4'h8, v); check("R3 R5 R7 after rising pins", v, 32'h0D);
        check("R9 requests follow pending", {26'd0, irq_req}, 32'h0D);

        pin_in = 6'h00; repeat (3) @(negedge clk);
        read_reg(4'h8, v); check("R4 R6 after falling pins", v, 32'h17);

        bus_write(4'h8, 32'h3E);
        read_reg(4'h8, v); check("R6 clear only zero bits", v, 32'h16);
        bus_write(4'h8, 32'h00);
        read_reg(4'h8, v); check("R6 clear all edge bits", v, 32'h10);

        // R9 pending captured while disabled
        bus_write(4'hC, 32'h0);
        pin_in = 6'h01; repeat (3) @(negedge clk);
        read_reg(4'h8, v); check("R9 capture while disabled", v, 32'h11);
        check("R9 requests gated off", {26'd0, irq_req}, 32'h0);
        bus_write(4'hC, 32'h1);
        check("R9 request after enable", {26'd0, irq_req}, 32'h01);

        // R6 edge and clear in the same cycle: edge wins
        pin_in = 6'h05;
        repeat (2) @(negedge clk);
        bus_write(4'h8, 32'h0);
        read_reg(4'h8, v); check("R6 edge beats clear", v, 32'h14);

        // random phase against the model
        for (int n = 0; n < 3000; n++) begin
            @(negedge clk);
            read_reg(4'h8, v);
            check("R7 random pending vs model", v, {26'd0, m_pend});
            check("R9 random requests vs model", {26'd0, irq_req}, {26'd0, m_pend & m_en});
            case ($urandom % 16)
                0: begin bus_addr = 4'h0; bus_wdata = $urandom; bus_wr = 1'b1; end
                1: begin bus_addr = 4'hC; bus_wdata = $urandom; bus_wr = 1'b1; end
                2, 3: begin bus_addr = 4'h8; bus_wdata = $urandom; bus_wr = 1'b1; end
                4: begin bus_addr = 4'h4; bus_wdata = $urandom; bus_wr = 1'b1; end
                default: bus_wr = 1'b0;
            endcase
            if ($urandom % 4 == 0) pin_in = pin_in ^ NP'($urandom);
        end
        @(negedge clk);
        bus_wr = 1'b0;
        @(negedge clk);
        read_reg(4'h0, v); check("R2 mode readback vs model", v, {8'd0, m_mode});
        finish_run();
    end
endmodule